// File: doc/BRIEF.md
# Peripheral Register Access Guard

This block sits between a peripheral bus and a small bank of configuration registers. Every request carries a word address, a direction, an access size, the requesting master's ID and a supervisor flag. The guard looks up the permission rule for that register and direction and compares it with the request and with the live protection flags. These flags are a per-CPU init lock, a global init-lock override, a safety lock with its own override, test mode, startup-in-progress and debug enable. The access then takes one of three paths: it completes, it is answered with a bus error, or it is quietly dropped.

A rule is a set of conditions. The privilege pair (user, supervisor) and the pair (test mode, startup) each pass if either member holds. All other selected conditions must hold together. Word 0 holds per-master enable bits, and master-ID conditions look these bits up. A configurable address window suppresses error responses: a violation there is answered as a normal completion, but nothing is written and read data is zero. One small state machine produces the response. It has four states: `ST_IDLE`, `ST_DONE` (allowed), `ST_FAULT` (error) and `ST_MUTE` (suppressed). From any state, the next state depends only on the verdict for the request sampled at the edge. With no request it is `ST_IDLE`; otherwise it is `ST_DONE`, `ST_FAULT` or `ST_MUTE`.

Top module: `reg_access_guard`

## Requirements
- R1: A permitted request presented at a clock edge gives `rsp_valid`=1 and `rsp_err`=0 after that edge, for one cycle. A permitted read returns the register's stored word on `rsp_rdata` in that same cycle.
- R2: A violation outside the suppression window raises `rsp_err` together with `rsp_valid` for exactly the response cycle of that request. With no further request, both are low one cycle later.
- R3: A violation at a word address inside the suppression window (default 6 to 11) gives `rsp_valid`=1 and `rsp_err`=0 with zero data.
- R4: A refused write leaves the target register unchanged. Any refused read, and every write response, returns zero data.
- R5: Word 4 is read-only. Any write to it faults, and reads return the STAT_VALUE parameter (default 32'h5AFE_0001).
- R6: A master-enable condition passes only when bit `req_mid` of word 0 is 1. Word 1 writes require master enable, supervisor and init-unlock. Word 2 writes require master enable plus user-or-supervisor.
- R7: A user condition passes only when `req_super`=0 and a supervisor condition only when `req_super`=1; when both are listed either passes. Word 0 writes need supervisor, init-unlock and 32-bit size. Reads of words 0 to 4 accept user or supervisor.
- R8: An init condition passes when some `cpu_lock` bit is 0 or `glob_lock` is 0. A per-CPU init condition looks only at that CPU's own `cpu_lock` bit.
- R9: A safety condition (word 3 writes, together with supervisor) passes when `safe_lock` is 0 or `safe_ovr_lock` is 0.
- R10: `req_size` encodes 0=8, 1=16, 2=32 and 3=64 bits. A 32-only condition accepts code 2 only. A 32-or-64 condition accepts codes 2 and 3.
- R11: Word 6 requires `test_mode` or `startup_run` in both directions, and 32-or-64 size for writes. Word 7 requires `debug_en` in both directions, and 32-bit size for writes.
- R12: Word 5 accepts only master ID 1 (CPU 1) in both directions. Its writes also need CPU 1's own lock bit clear.
- R13: Word addresses from NREG (default 8) upward are undefined, and every access to them is a violation.
- R14: After reset, `rsp_valid` and `rsp_err` are low and every writable register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_size | input | 2 | Access size code |
| req_mid | input | MID_W | Requesting master ID |
| req_super | input | 1 | 1 = supervisor, 0 = user |
| req_wdata | input | 32 | Write data |
| cpu_lock | input | NCPU | Per-CPU init lock, 1 = locked |
| glob_lock | input | 1 | Global init-lock override, 1 = locked |
| safe_lock | input | 1 | Safety init lock |
| safe_ovr_lock | input | 1 | Safety lock override |
| test_mode | input | 1 | Test mode active |
| startup_run | input | 1 | Startup firmware running |
| debug_en | input | 1 | On-chip debug enabled |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume that the protection flags and request fields are stable across the sampling edge. They also assume that `req_mid` is compared only against the master-enable bits, which exist for every ID. The bench drives all inputs on the falling edge and holds them through the next rising edge, so each request is seen exactly once with settled flags. The bench drops `req_valid` between table entries, so every response is followed by an idle cycle. The directed part then issues faulting requests back to back to cover repeated error cycles.

// File: rtl/rag_pkg.sv
package rag_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        V_PASS  = 2'd0,
        V_FAULT = 2'd1,
        V_MUTE  = 2'd2
    } verdict_e;

    // One direction's permission rule for one register word.
    typedef struct packed {
        logic       deny;      // every access in this direction is refused
        logic       men;       // requesting master must be enabled
        logic       usr;       // user privilege accepted
        logic       sup;       // supervisor privilege accepted
        logic       init_any;  // some init lock must be open
        logic       init_cpu;  // the named CPU's own lock must be open
        logic       cpu_only;  // only the named CPU's master ID
        logic       safe;      // safety lock must be open
        logic       tst;       // test mode accepted
        logic       boot;      // startup accepted
        logic       dbg;       // debug must be enabled
        logic       w32;       // 32-bit size only
        logic       w3264;     // 32- or 64-bit size only
        logic [1:0] cpu;       // CPU index for cpu_only / init_cpu
    } rule_t;

    function automatic rule_t rule_of(input int idx, input logic wr);
        rule_t r;
        r = '0;
        case (idx)
            0: if (wr) begin r.sup = 1'b1; r.init_any = 1'b1; r.w32 = 1'b1; end
               else    begin r.usr = 1'b1; r.sup = 1'b1; end
            1: if (wr) begin r.men = 1'b1; r.sup = 1'b1; r.init_any = 1'b1; end
               else    begin r.usr = 1'b1; r.sup = 1'b1; end
            2: begin
                   r.usr = 1'b1; r.sup = 1'b1;
                   r.men = wr;
               end
            3: if (wr) begin r.sup = 1'b1; r.safe = 1'b1; end
               else    begin r.usr = 1'b1; r.sup = 1'b1; end
            4: if (wr) r.deny = 1'b1;
               else    begin r.usr = 1'b1; r.sup = 1'b1; end
            5: begin
                   r.cpu_only = 1'b1; r.cpu = 2'd1;
                   r.init_cpu = wr;
               end
            6: begin
                   r.tst = 1'b1; r.boot = 1'b1;
                   r.w3264 = wr;
               end
            7: begin
                   r.dbg = 1'b1;
                   r.w32 = wr;
               end
            default: r.deny = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rag_cond_eval.sv
module rag_cond_eval
    import rag_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NREG   = 8,
    parameter int MID_W  = 5,
    parameter int NCPU   = 2,
    parameter int NBE_LO = 6,
    parameter int NBE_HI = 11,
    localparam int MEN_W = 1 << MID_W,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [1:0]        size,
    input  logic [MID_W-1:0]  mid,
    input  logic              sup,
    input  logic [MEN_W-1:0]  men,
    input  logic [NCPU-1:0]   cpu_lock,
    input  logic              glob_lock,
    input  logic              safe_lock,
    input  logic              safe_ovr_lock,
    input  logic              test_mode,
    input  logic              startup_run,
    input  logic              debug_en,
    output verdict_e          verdict
);

    rule_t rd_tab [NREG];
    rule_t wr_tab [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_rule
            assign rd_tab[g] = rule_of(g, 1'b0);
            assign wr_tab[g] = rule_of(g, 1'b1);
        end
    endgenerate

    rule_t      r;
    logic       defined, in_quiet, own_free, pass;
    logic       priv_ok, gate_ok, width_ok, men_ok, init_ok, own_ok;
    logic       safe_ok, dbg_ok, cpu_ok;
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx      = IDX_W'(addr);
        defined  = int'(addr) < NREG;
        in_quiet = (int'(addr) >= NBE_LO) && (int'(addr) <= NBE_HI);
        r        = '0;
        r.deny   = 1'b1;
        if (defined) r = wr ? wr_tab[idx] : rd_tab[idx];

        own_free = 1'b0;
        for (int k = 0; k < NCPU; k++) begin
            if (k == int'(r.cpu)) own_free = ~cpu_lock[k];
        end

        priv_ok  = !(r.usr || r.sup) || (r.usr && !sup) || (r.sup && sup);
        gate_ok  = !(r.tst || r.boot) || (r.tst && test_mode) || (r.boot && startup_run);
        width_ok = r.w32   ? (size == SZ_32) :
                   r.w3264 ? ((size == SZ_32) || (size == SZ_64)) : 1'b1;
        men_ok   = !r.men      || men[mid];
        init_ok  = !r.init_any || !(&cpu_lock) || !glob_lock;
        own_ok   = !r.init_cpu || own_free;
        safe_ok  = !r.safe     || !safe_lock || !safe_ovr_lock;
        dbg_ok   = !r.dbg      || debug_en;
        cpu_ok   = !r.cpu_only || (mid == MID_W'(r.cpu));

        pass = !r.deny && priv_ok && gate_ok && width_ok && men_ok &&
               init_ok && own_ok && safe_ok && dbg_ok && cpu_ok;

        verdict = pass ? V_PASS : (in_quiet ? V_MUTE : V_FAULT);
    end

    // Undefined words never pass (R13).
    always_comb begin
        assert_undef_denied_R13: assert (defined || verdict != V_PASS);
    end

endmodule

// File: rtl/rag_regfile.sv
module rag_regfile
    import rag_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int          NREG       = 8,
    parameter int          STAT_IDX   = 4,
    parameter logic [31:0] STAT_VALUE = 32'h5AFE_0001,
    localparam int         IDX_W      = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     word0
);

    logic [DW-1:0]    regs [NREG];
    logic [IDX_W-1:0] idx;

    assign idx   = IDX_W'(addr);
    assign word0 = regs[0];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_word
            if (g == STAT_IDX) begin : g_ro
                assign regs[g] = STAT_VALUE;
            end else begin : g_rw
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)                               regs[g] <= '0;
                    else if (wr_en && idx == IDX_W'(g))       regs[g] <= wdata;
                end

                // A word not granted a write keeps its value (R4).
                assert_blocked_write_stable_R4: assert property (
                    @(posedge clk) disable iff (!rst_n)
                    !(wr_en && idx == IDX_W'(g)) |=> $stable(regs[g]));
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_en)  rdata <= regs[idx];
        else             rdata <= '0;
    end

endmodule

// File: rtl/rag_resp_fsm.sv
module rag_resp_fsm
    import rag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  verdict_e verdict,
    output logic     rsp_valid,
    output logic     rsp_err
);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2,
        ST_MUTE  = 2'd3
    } state_e;

    state_e state, state_nx;

    always_comb begin
        state_nx = ST_IDLE;
        if (req_valid) begin
            unique case (verdict)
                V_PASS:  state_nx = ST_DONE;
                V_FAULT: state_nx = ST_FAULT;
                V_MUTE:  state_nx = ST_MUTE;
                default: state_nx = ST_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  begin rsp_valid = 1'b0; rsp_err = 1'b0; end
            ST_DONE:  begin rsp_valid = 1'b1; rsp_err = 1'b0; end
            ST_FAULT: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            ST_MUTE:  begin rsp_valid = 1'b1; rsp_err = 1'b0; end
            default:  begin rsp_valid = 1'b0; rsp_err = 1'b0; end
        endcase
    end

    logic seen_edge;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_edge <= 1'b0;
        else        seen_edge <= 1'b1;
    end

    // Responses appear only one cycle after a request (R1, R2).
    assert_no_spurious_rsp_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (seen_edge && !$past(req_valid)) |-> !rsp_valid);

    assert_err_has_valid_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    assert_err_single_cycle_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rsp_err && !req_valid) |=> !rsp_err);

endmodule

// File: rtl/reg_access_guard.sv
module reg_access_guard
    import rag_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int          NREG       = 8,
    parameter int          MID_W      = 5,
    parameter int          NCPU       = 2,
    parameter int          NBE_LO     = 6,
    parameter int          NBE_HI     = 11,
    parameter int          STAT_IDX   = 4,
    parameter logic [31:0] STAT_VALUE = 32'h5AFE_0001,
    localparam int         MEN_W      = 1 << MID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [MID_W-1:0]  req_mid,
    input  logic              req_super,
    input  logic [31:0]       req_wdata,
    input  logic [NCPU-1:0]   cpu_lock,
    input  logic              glob_lock,
    input  logic              safe_lock,
    input  logic              safe_ovr_lock,
    input  logic              test_mode,
    input  logic              startup_run,
    input  logic              debug_en,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);

    verdict_e      verdict;
    logic [DW-1:0] word0;
    logic          granted, wr_en, rd_en;

    assign granted = req_valid && (verdict == V_PASS);
    assign wr_en   = granted && req_write;
    assign rd_en   = granted && !req_write;

    rag_cond_eval #(
        .ADDR_W(ADDR_W), .NREG(NREG), .MID_W(MID_W), .NCPU(NCPU),
        .NBE_LO(NBE_LO), .NBE_HI(NBE_HI)
    ) u_eval (
        .addr(req_addr), .wr(req_write), .size(req_size), .mid(req_mid),
        .sup(req_super), .men(word0[MEN_W-1:0]), .cpu_lock(cpu_lock),
        .glob_lock(glob_lock), .safe_lock(safe_lock),
        .safe_ovr_lock(safe_ovr_lock), .test_mode(test_mode),
        .startup_run(startup_run), .debug_en(debug_en), .verdict(verdict)
    );

    rag_regfile #(
        .ADDR_W(ADDR_W), .NREG(NREG), .STAT_IDX(STAT_IDX), .STAT_VALUE(STAT_VALUE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(req_addr), .wdata(req_wdata), .rdata(rsp_rdata), .word0(word0)
    );

    rag_resp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .verdict(verdict),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err)
    );

    // Faulting responses carry no data (R4).
    assert_fault_zero_data_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    // Undefined words never return data (R13).
    assert_undef_zero_data_R13: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_addr) >= NREG) |=> (rsp_rdata == '0));

    // Read-only word refuses every write (R5).
    assert_readonly_write_refused_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && int'(req_addr) == STAT_IDX) |=> !(rsp_valid && !rsp_err && (STAT_IDX < NBE_LO || STAT_IDX > NBE_HI)));

endmodule

// File: tb/reg_access_guard_tb.sv
module reg_access_guard_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] STAT_VALUE = 32'h5AFE_0001;
    localparam logic [1:0]  PAS = 2'd0, FLT = 2'd1, MUT = 2'd2;
    localparam logic [7:0]  L   = 8'b11_111_000;  // all locks closed, modes off

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [1:0]  size;
        logic [4:0]  mid;
        logic        sup;
        logic [31:0] wdata;
        logic [7:0]  flg;   // {cpu1,cpu0,glob,safe,sovr,test,start,dbg}
        logic [1:0]  exp;
        logic [31:0] erd;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 34;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 4'd0, 2'd2, 5'd0, 1'b1, 32'h6,        L,            FLT, 32'h0,        4'd8 },  // R8 all locked
        '{1'b1, 4'd0, 2'd2, 5'd0, 1'b1, 32'h6,        8'b10111000,  PAS, 32'h0,        4'd8 },  // R8 cpu0 open
        '{1'b0, 4'd0, 2'd2, 5'd0, 1'b0, 32'h0,        L,            PAS, 32'h6,        4'd7 },  // R7 user read
        '{1'b1, 4'd0, 2'd2, 5'd0, 1'b0, 32'hF,        8'b10111000,  FLT, 32'h0,        4'd7 },  // R7 user write
        '{1'b1, 4'd1, 2'd2, 5'd1, 1'b1, 32'hA5A50001, 8'b11011000,  PAS, 32'h0,        4'd6 },  // R6 enabled
        '{1'b1, 4'd1, 2'd2, 5'd3, 1'b1, 32'hDEAD,     8'b11011000,  FLT, 32'h0,        4'd6 },  // R6 disabled
        '{1'b0, 4'd1, 2'd2, 5'd3, 1'b0, 32'h0,        L,            PAS, 32'hA5A50001, 4'd4 },  // R4 unchanged
        '{1'b1, 4'd2, 2'd2, 5'd2, 1'b0, 32'h1234,     L,            PAS, 32'h0,        4'd7 },  // R7 pair user
        '{1'b1, 4'd2, 2'd2, 5'd2, 1'b1, 32'h5678,     L,            PAS, 32'h0,        4'd7 },  // R7 pair super
        '{1'b1, 4'd2, 2'd2, 5'd0, 1'b1, 32'h9999,     L,            FLT, 32'h0,        4'd6 },  // R6 bit0 clear
        '{1'b0, 4'd2, 2'd2, 5'd0, 1'b0, 32'h0,        L,            PAS, 32'h5678,     4'd1 },  // R1 read back
        '{1'b1, 4'd3, 2'd2, 5'd0, 1'b1, 32'h33,       L,            FLT, 32'h0,        4'd9 },  // R9 locked
        '{1'b1, 4'd3, 2'd2, 5'd0, 1'b1, 32'h33,       8'b11101000,  PAS, 32'h0,        4'd9 },  // R9 safe open
        '{1'b1, 4'd3, 2'd2, 5'd0, 1'b1, 32'h44,       8'b11110000,  PAS, 32'h0,        4'd9 },  // R9 override open
        '{1'b1, 4'd4, 2'd2, 5'd0, 1'b1, 32'hBAD,      8'b00000000,  FLT, 32'h0,        4'd5 },  // R5 write
        '{1'b0, 4'd4, 2'd2, 5'd0, 1'b1, 32'h0,        8'b00000000,  PAS, STAT_VALUE,   4'd5 },  // R5 read
        '{1'b1, 4'd5, 2'd2, 5'd1, 1'b1, 32'h55,       8'b01111000,  PAS, 32'h0,        4'd12},  // R12 own lock open
        '{1'b1, 4'd5, 2'd2, 5'd1, 1'b1, 32'hAA,       8'b10111000,  FLT, 32'h0,        4'd8 },  // R8 other cpu open only
        '{1'b0, 4'd5, 2'd2, 5'd0, 1'b1, 32'h0,        L,            FLT, 32'h0,        4'd12},  // R12 wrong master
        '{1'b0, 4'd5, 2'd2, 5'd1, 1'b1, 32'h0,        L,            PAS, 32'h55,       4'd12},  // R12 right master
        '{1'b0, 4'd6, 2'd2, 5'd0, 1'b1, 32'h0,        L,            MUT, 32'h0,        4'd3 },  // R3 quiet read
        '{1'b0, 4'd6, 2'd2, 5'd0, 1'b1, 32'h0,        8'b11111010,  PAS, 32'h0,        4'd11},  // R11 startup
        '{1'b1, 4'd6, 2'd3, 5'd0, 1'b1, 32'h66,       8'b11111100,  PAS, 32'h0,        4'd10},  // R10 64-bit ok
        '{1'b1, 4'd6, 2'd1, 5'd0, 1'b1, 32'hBB,       8'b11111100,  MUT, 32'h0,        4'd10},  // R10 16-bit refused
        '{1'b0, 4'd6, 2'd2, 5'd0, 1'b1, 32'h0,        8'b11111100,  PAS, 32'h66,       4'd4 },  // R4 quiet write dropped
        '{1'b1, 4'd7, 2'd2, 5'd0, 1'b1, 32'hCC,       L,            MUT, 32'h0,        4'd3 },  // R3 quiet write
        '{1'b1, 4'd7, 2'd2, 5'd0, 1'b1, 32'h77,       8'b11111001,  PAS, 32'h0,        4'd11},  // R11 debug
        '{1'b1, 4'd7, 2'd0, 5'd0, 1'b1, 32'hDD,       8'b11111001,  MUT, 32'h0,        4'd10},  // R10 8-bit refused
        '{1'b0, 4'd7, 2'd2, 5'd0, 1'b1, 32'h0,        8'b11111001,  PAS, 32'h77,       4'd11},  // R11 read back
        '{1'b0, 4'd9, 2'd2, 5'd0, 1'b1, 32'h0,        L,            MUT, 32'h0,        4'd13},  // R13 quiet undefined
        '{1'b0, 4'd12,2'd2, 5'd0, 1'b1, 32'h0,        L,            FLT, 32'h0,        4'd13},  // R13 undefined read
        '{1'b1, 4'd15,2'd2, 5'd0, 1'b1, 32'hEE,       L,            FLT, 32'h0,        4'd13},  // R13 undefined write
        '{1'b0, 4'd7, 2'd2, 5'd0, 1'b1, 32'h0,        L,            MUT, 32'h0,        4'd4 },  // R4 refused read zero
        '{1'b0, 4'd3, 2'd2, 5'd0, 1'b0, 32'h0,        L,            PAS, 32'h44,       4'd1 }   // R1 user read
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [4:0]  req_mid = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  cpu_lock = 2'b11;
    logic        glob_lock = 1'b1, safe_lock = 1'b1, safe_ovr_lock = 1'b1;
    logic        test_mode = 1'b0, startup_run = 1'b0, debug_en = 1'b0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    int          checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_access_guard u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_mid(req_mid),
        .req_super(req_super), .req_wdata(req_wdata), .cpu_lock(cpu_lock),
        .glob_lock(glob_lock), .safe_lock(safe_lock), .safe_ovr_lock(safe_ovr_lock),
        .test_mode(test_mode), .startup_run(startup_run), .debug_en(debug_en),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_size = v.size;
        req_mid = v.mid; req_super = v.sup; req_wdata = v.wdata;
        {cpu_lock, glob_lock, safe_lock, safe_ovr_lock, test_mode, startup_run, debug_en} = v.flg;
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R14 outputs quiet in and after reset
        chk("R14 valid in reset", 32'(rsp_valid), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R14 valid after reset", 32'(rsp_valid), 32'd0);
        chk("R14 err after reset", 32'(rsp_err), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i]);
            chk($sformatf("R%0d vec %0d valid", VEC[i].rq, i), 32'(rsp_valid), 32'd1);
            chk($sformatf("R%0d vec %0d err", VEC[i].rq, i), 32'(rsp_err), 32'(VEC[i].exp == FLT));
            chk($sformatf("R%0d vec %0d rdata", VEC[i].rq, i), rsp_rdata, VEC[i].erd);
            @(negedge clk) req_valid = 1'b0;
        end

        // R2: back-to-back faults, then idle
        issue('{1'b0, 4'd12, 2'd2, 5'd0, 1'b1, 32'h0, L, FLT, 32'h0, 4'd2});
        chk("R2 first fault", 32'(rsp_err), 32'd1);
        issue('{1'b1, 4'd4, 2'd2, 5'd0, 1'b1, 32'h1, L, FLT, 32'h0, 4'd2});
        chk("R2 second fault", 32'(rsp_err), 32'd1);
        @(negedge clk) req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R2 err drops", 32'(rsp_err), 32'd0);
        chk("R2 valid drops", 32'(rsp_valid), 32'd0);

        // R14: reset clears writable words, read-only word keeps its value
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        issue('{1'b0, 4'd0, 2'd2, 5'd0, 1'b1, 32'h0, L, PAS, 32'h0, 4'd14});
        chk("R14 word0 cleared", rsp_rdata, 32'h0);
        @(negedge clk) req_valid = 1'b0;
        issue('{1'b0, 4'd4, 2'd2, 5'd0, 1'b1, 32'h0, L, PAS, STAT_VALUE, 4'd14});
        chk("R14 read-only word", rsp_rdata, STAT_VALUE);
        @(negedge clk) req_valid = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule